// File: doc/BRIEF.md
# Interrupt Flag and Call Injector

This block gathers interrupt requests from three I/O sources: an analog sample streamer, a video engine and a serial link. Each request sets a sticky flag bit and arms a one-shot injection. On the next instruction fetch the CPU makes, the block replaces the fetched instruction with a call to offset zero of the current home page. In the same cycle it asks the CPU to push the current program counter onto the return stack.

There is no vector table. A single service entry serves every source, so the routine reads the flag register to learn which sources fired. It then clears the flags it has handled by writing to the register. The low address bits of that write form the clear mask, and the data bits are ignored.

While a forced call is waiting to be fetched, further requests only set flags and do not arm a second call. A burst of requests therefore costs the CPU one entry into the service routine.

Top module: `irq_call_injector`

## Requirements
- R1: After reset all flag bits read as zero, and no instruction fetch is substituted until a request arrives.
- R2: A high bit on `srcReq` sets the matching flag at the next clock edge. The bit positions are 0 for analog, 1 for video and 2 for serial.
- R3: When a call is armed, the next cycle with `fetchReq` high drives `fetchSubst` high. In that cycle `callTarget` is `homePage` followed by `PAGE_OFS_W` zero bits. A request at edge t can be taken by a fetch in cycle t+1 at the earliest.
- R4: In the substitution cycle `pushReq` is high and `pushData` equals `fetchPc`. In every other cycle both are zero.
- R5: Each armed call is taken exactly once, and the arming clears itself when the call is taken. Later fetches run unmodified until a new request arrives.
- R6: While a call is armed, any request arriving before or in the cycle it is taken leaves the call count unchanged. Such requests still set their flags.
- R7: A cycle with `regSel` and `regWe` both high clears every flag whose bit is set in `regAddrLow`. Offsets 1, 2 and 4 each clear one flag, and offset 7 clears all three.
- R8: If a request and a clear hit the same flag in the same cycle, the flag stays set.
- R9: While `regSel` is high and `regWe` is low, `regRdata` shows the flags. When the register is not being read, `regRdata` is zero. Reading does not change any flag.
- R10: Flags are sticky. They stay set across fetches and across the taking of the call, and only a clearing write removes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcReq | input | 3 | Request strobes: bit 0 analog, bit 1 video, bit 2 serial |
| fetchReq | input | 1 | The CPU is loading an instruction in this cycle |
| fetchPc | input | ADDR_W | Program counter of the current fetch |
| homePage | input | ADDR_W-PAGE_OFS_W | Current home page number |
| fetchSubst | output | 1 | Replace this fetch with the forced call |
| callTarget | output | ADDR_W | Call address: offset zero of the home page |
| pushReq | output | 1 | Push `pushData` onto the return stack |
| pushData | output | ADDR_W | Program counter to save |
| regSel | input | 1 | Flag register access in this cycle |
| regWe | input | 1 | The access is a write, which clears flags |
| regAddrLow | input | 3 | Low address bits of the access, used as the clear mask |
| regRdata | output | 3 | Flag read data |

## Verification
Single requests from each source confirm that each source maps to its own flag bit. A run of staggered requests followed by one fetch, with another request landing in the fetch cycle, separates a correct design that makes one call from one that re-arms. Clearing writes at offsets 1, 2, 4 and 7 against a full flag set show whether the address decodes to a mask or to a single index. A request coinciding with its own clear exposes a wrong set/clear priority. A long random mix of requests, fetches, reads and clears, with a moving home page, is compared every cycle against a behavioural model of the flags and the pending call.

// File: rtl/intinj_pkg.sv
package intinj_pkg;

  // Number of interrupt sources; bit order is analog, video, serial.
  localparam int unsigned IRQ_SRC_CNT = 3;

  typedef logic [IRQ_SRC_CNT-1:0] srcMask_t;

  typedef enum logic [0:0] {
    INJ_IDLE  = 1'b0,
    INJ_ARMED = 1'b1
  } injState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic     take;     // forced call goes out on this fetch
    logic     rdEn;     // flag register read
    srcMask_t setMask;  // flags to set
    srcMask_t clrMask;  // flags to clear
  } ctlStrobes_t;

endpackage

// File: rtl/intinj_ctrl.sv
module intinj_ctrl
  import intinj_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  srcMask_t    srcReq,
  input  logic        fetchReq,
  input  logic        regSel,
  input  logic        regWe,
  input  srcMask_t    regAddrLow,
  output ctlStrobes_t strobes
);

  injState_t stateQ, stateD;
  logic      takeNow;
  logic      anyReq;

  assign anyReq  = |srcReq;
  assign takeNow = (stateQ == INJ_ARMED) && fetchReq;

  // Arming is one-shot: requests while armed (even in the take cycle)
  // are absorbed and only set flags.
  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      INJ_IDLE:  if (anyReq)  stateD = INJ_ARMED;
      INJ_ARMED: if (takeNow) stateD = INJ_IDLE;
      default:   stateD = INJ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= INJ_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobes.take    = takeNow;
    strobes.rdEn    = regSel && !regWe;
    strobes.setMask = srcReq;
    strobes.clrMask = (regSel && regWe) ? regAddrLow : '0;
  end

endmodule

// File: rtl/intinj_dp.sv
module intinj_dp
  import intinj_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned PAGE_OFS_W = 10
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctlStrobes_t                  strobes,
  input  logic [ADDR_W-PAGE_OFS_W-1:0] homePage,
  input  logic [ADDR_W-1:0]            fetchPc,
  output srcMask_t                     flagState,
  output logic [ADDR_W-1:0]            callTarget,
  output logic [ADDR_W-1:0]            pushData,
  output srcMask_t                     regRdata
);

  localparam int unsigned PAGE_W = ADDR_W - PAGE_OFS_W;

  // One sticky flag per source; a set beats a clear in the same cycle.
  for (genvar g = 0; g < IRQ_SRC_CNT; g++) begin : g_flag
    logic flagQ;
    always_ff @(posedge clk) begin
      if (!rstN)                   flagQ <= 1'b0;
      else if (strobes.setMask[g]) flagQ <= 1'b1;
      else if (strobes.clrMask[g]) flagQ <= 1'b0;
    end
    assign flagState[g] = flagQ;
  end

  assign callTarget = {homePage[PAGE_W-1:0], {PAGE_OFS_W{1'b0}}};
  assign pushData   = strobes.take ? fetchPc : '0;
  assign regRdata   = strobes.rdEn ? flagState : '0;

endmodule

// File: rtl/irq_call_injector.sv
module irq_call_injector
  import intinj_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned PAGE_OFS_W = 10
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [IRQ_SRC_CNT-1:0]       srcReq,
  input  logic                         fetchReq,
  input  logic [ADDR_W-1:0]            fetchPc,
  input  logic [ADDR_W-PAGE_OFS_W-1:0] homePage,
  output logic                         fetchSubst,
  output logic [ADDR_W-1:0]            callTarget,
  output logic                         pushReq,
  output logic [ADDR_W-1:0]            pushData,
  input  logic                         regSel,
  input  logic                         regWe,
  input  logic [IRQ_SRC_CNT-1:0]       regAddrLow,
  output logic [IRQ_SRC_CNT-1:0]       regRdata
);

  ctlStrobes_t strobes;
  srcMask_t    flagState;

  intinj_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .srcReq     (srcReq),
    .fetchReq   (fetchReq),
    .regSel     (regSel),
    .regWe      (regWe),
    .regAddrLow (regAddrLow),
    .strobes    (strobes)
  );

  intinj_dp #(
    .ADDR_W     (ADDR_W),
    .PAGE_OFS_W (PAGE_OFS_W)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .homePage   (homePage),
    .fetchPc    (fetchPc),
    .flagState  (flagState),
    .callTarget (callTarget),
    .pushData   (pushData),
    .regRdata   (regRdata)
  );

  assign fetchSubst = strobes.take;
  assign pushReq    = strobes.take;

endmodule

// File: rtl/intinj_chk.sv
module intinj_chk
  import intinj_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned PAGE_OFS_W = 10
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [IRQ_SRC_CNT-1:0]       srcReq,
  input logic                         fetchReq,
  input logic [ADDR_W-1:0]            fetchPc,
  input logic [ADDR_W-PAGE_OFS_W-1:0] homePage,
  input logic                         fetchSubst,
  input logic [ADDR_W-1:0]            callTarget,
  input logic                         pushReq,
  input logic [ADDR_W-1:0]            pushData,
  input logic                         regSel,
  input logic                         regWe,
  input logic [IRQ_SRC_CNT-1:0]       regAddrLow,
  input logic [IRQ_SRC_CNT-1:0]       regRdata,
  input logic [IRQ_SRC_CNT-1:0]       flagState
);

  assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (srcReq != '0) |=> ((flagState & $past(srcReq)) == $past(srcReq)));

  assert_call_follows_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    (srcReq != '0 && !fetchSubst) |=> (!fetchReq || fetchSubst));

  assert_call_target_R3: assert property (@(posedge clk) disable iff (!rstN)
    fetchSubst |-> (callTarget[PAGE_OFS_W-1:0] == '0 &&
                    callTarget[ADDR_W-1:PAGE_OFS_W] == homePage));

  assert_push_pc_R4: assert property (@(posedge clk) disable iff (!rstN)
    fetchSubst |-> (pushReq && pushData == fetchPc));

  assert_subst_on_fetch_R5: assert property (@(posedge clk) disable iff (!rstN)
    fetchSubst |-> fetchReq);

  assert_single_call_R6: assert property (@(posedge clk) disable iff (!rstN)
    fetchSubst |=> !fetchSubst);

  assert_clear_mask_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && regWe) |=> ((flagState & $past(regAddrLow & ~srcReq)) == '0));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && regWe && (srcReq & regAddrLow) != '0)
      |=> ((flagState & $past(srcReq & regAddrLow)) != '0));

  assert_read_data_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && !regWe) |-> (regRdata == flagState));

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(regSel && regWe) |=> ((flagState & $past(flagState)) == $past(flagState)));

endmodule

bind irq_call_injector intinj_chk #(
  .ADDR_W     (ADDR_W),
  .PAGE_OFS_W (PAGE_OFS_W)
) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .srcReq     (srcReq),
  .fetchReq   (fetchReq),
  .fetchPc    (fetchPc),
  .homePage   (homePage),
  .fetchSubst (fetchSubst),
  .callTarget (callTarget),
  .pushReq    (pushReq),
  .pushData   (pushData),
  .regSel     (regSel),
  .regWe      (regWe),
  .regAddrLow (regAddrLow),
  .regRdata   (regRdata),
  .flagState  (flagState)
);

// File: tb/test_irq_call_injector.sv
`timescale 1ns/1ps
module test_irq_call_injector;

  localparam int ADDR_W     = 20;
  localparam int PAGE_OFS_W = 10;
  localparam int PAGE_W     = ADDR_W - PAGE_OFS_W;

  logic                 clk = 1'b0;
  logic                 rstN;
  logic [2:0]           srcReq;
  logic                 fetchReq;
  logic [ADDR_W-1:0]    fetchPc;
  logic [PAGE_W-1:0]    homePage;
  logic                 fetchSubst;
  logic [ADDR_W-1:0]    callTarget;
  logic                 pushReq;
  logic [ADDR_W-1:0]    pushData;
  logic                 regSel;
  logic                 regWe;
  logic [2:0]           regAddrLow;
  logic [2:0]           regRdata;

  int  vectors     = 0;
  int  miscompares = 0;
  bit  finished    = 0;
  int  callCount   = 0;

  // Behavioural reference state
  int  refFlags = 0;
  bit  refPend  = 0;

  always #2.5 clk = ~clk;

  irq_call_injector #(.ADDR_W(ADDR_W), .PAGE_OFS_W(PAGE_OFS_W)) i_irq_call_injector (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .fetchReq(fetchReq), .fetchPc(fetchPc),
    .homePage(homePage), .fetchSubst(fetchSubst), .callTarget(callTarget),
    .pushReq(pushReq), .pushData(pushData), .regSel(regSel), .regWe(regWe),
    .regAddrLow(regAddrLow), .regRdata(regRdata)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // One cycle: drive at negedge, compare before posedge, advance the model.
  task automatic step(input string tag, input logic [2:0] req, input bit fet,
                      input int pc, input bit sel, input bit we, input logic [2:0] adr);
    bit expSubst;
    int clr;
    @(negedge clk);
    srcReq = req; fetchReq = fet; fetchPc = pc[ADDR_W-1:0];
    regSel = sel; regWe = we; regAddrLow = adr;
    #1;
    expSubst = refPend && fet;
    check(tag,  "fetchSubst", int'(fetchSubst), int'(expSubst));
    check("R4", "pushReq",    int'(pushReq),    int'(expSubst));
    check("R4", "pushData",   int'(pushData),   expSubst ? (pc & ((1 << ADDR_W) - 1)) : 0);
    check("R3", "callTarget", int'(callTarget), int'(homePage) * (1 << PAGE_OFS_W));
    check(tag,  "regRdata",   int'(regRdata),   (sel && !we) ? refFlags : 0);
    if (expSubst) callCount++;
    @(posedge clk);
    clr = (sel && we) ? int'(adr) : 0;
    refFlags = (refFlags & ~clr & 7) | int'(req);
    if (refPend) refPend = !expSubst;
    else         refPend = (req != 3'b000);
  endtask

  task automatic readFlags(input string tag);
    step(tag, 3'b000, 0, 0, 1, 0, 3'b000);
  endtask

  task automatic clearFlags(input string tag, input logic [2:0] adr);
    step(tag, 3'b000, 0, 0, 1, 1, adr);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int calls0;
    rstN = 0; srcReq = 0; fetchReq = 0; fetchPc = 0; homePage = 10'h155;
    regSel = 0; regWe = 0; regAddrLow = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1: clean state after reset
    readFlags("R1");
    step("R1", 3'b000, 1, 20'h00100, 0, 0, 3'b000);

    // R2 / R3 / R5: single analog request, one call, then plain fetches
    step("R2", 3'b001, 0, 0, 0, 0, 3'b000);
    readFlags("R2");
    step("R3", 3'b000, 1, 20'h12345, 0, 0, 3'b000);
    step("R5", 3'b000, 1, 20'h12346, 0, 0, 3'b000);
    step("R5", 3'b000, 1, 20'h12347, 0, 0, 3'b000);
    // R10: flag survives the call
    readFlags("R10");

    // R3: earliest take is the cycle after the request edge
    clearFlags("R7", 3'b111);
    homePage = 10'h3A0;
    step("R3", 3'b100, 1, 20'h0ABCD, 0, 0, 3'b000);
    step("R3", 3'b000, 1, 20'h0ABCE, 0, 0, 3'b000);

    // R6: staggered requests, plus one in the take cycle, make one call
    clearFlags("R7", 3'b111);
    calls0 = callCount;
    step("R6", 3'b010, 0, 0, 0, 0, 3'b000);
    step("R6", 3'b100, 0, 0, 0, 0, 3'b000);
    step("R6", 3'b001, 1, 20'h54321, 0, 0, 3'b000);
    step("R6", 3'b000, 1, 20'h54322, 0, 0, 3'b000);
    step("R6", 3'b000, 1, 20'h54323, 0, 0, 3'b000);
    check("R6", "callCount", callCount - calls0, 1);
    readFlags("R6");

    // R7: each clear offset against a full flag set
    clearFlags("R7", 3'b001); readFlags("R7");
    clearFlags("R7", 3'b100); readFlags("R7");
    clearFlags("R7", 3'b010); readFlags("R7");
    step("R7", 3'b111, 0, 0, 0, 0, 3'b000);
    step("R7", 3'b000, 1, 20'h00400, 0, 0, 3'b000);
    clearFlags("R7", 3'b111); readFlags("R7");

    // R8: request coinciding with its own clear
    step("R8", 3'b011, 0, 0, 1, 1, 3'b011);
    readFlags("R8");
    step("R8", 3'b000, 1, 20'h00777, 0, 0, 3'b000);

    // R9: reads have no side effect; unselected returns zero
    readFlags("R9"); readFlags("R9");
    step("R9", 3'b000, 0, 0, 0, 0, 3'b000);
    step("R9", 3'b000, 0, 0, 0, 1, 3'b111);
    readFlags("R9");
    clearFlags("R7", 3'b111);

    // Random mix against the model
    for (int n = 0; n < 2000; n++) begin
      logic [2:0] rq;
      logic [2:0] ad;
      int pc;
      bit fe, se, we;
      rq = (($urandom % 6) == 0) ? 3'($urandom) : 3'b000;
      ad = 3'($urandom);
      pc = int'($urandom & 32'hFFFFF);
      fe = ($urandom % 3) != 0;
      se = ($urandom % 3) == 0;
      we = ($urandom % 2) == 0;
      if (($urandom % 50) == 0) homePage = 10'($urandom);
      step("R5", rq, fe, pc, se, we, ad);
    end

    finish_run();
  end

endmodule